// File: doc/BRIEF.md
# Dual-Bank 3x3 Kernel Coefficient File

This block holds two complete sets of 3x3 filter weights and presents one of them to a nine-multiplier array. Each set has nine 8-bit weights, tap A through tap I, and each tap drives one multiplier. A host loads weights over a narrow write port. The port has a 3-bit address, an 8-bit data bus and two active-low strobes, chip-select and load. A write is taken at the end of the interval in which both strobes are low. The strobes are not related to the block clock, so they pass through a synchronizer before the write is detected.

Addressing a bank does two things. It starts a sequential load, so successive writes fill tap A, then tap B, up to tap I. It also makes that bank the one that feeds the multipliers. The select is a single register, so all nine outputs move to the other bank on one clock edge and no processing cycle is lost. The weights of the bank not in use stay untouched. A host can therefore fill one bank at its own pace and swap to it with one write, or return later to the other bank without reloading it.

Top module: `coef_bank_file`

## Requirements
- R1: While reset is asserted, and immediately after it is released, all 72 output bits are zero and bank 0 is the active bank.
- R2: Nine writes in a row to one bank address load tap A, then B, up to tap I. Tap k (A=0 through I=8) appears on coef_out[8k+7:8k].
- R3: A write to a bank address makes that bank the active one. All nine outputs then show that bank's weights.
- R4: When all nine taps of a bank have been written, further writes to the same address change nothing until the address changes.
- R5: A write whose address differs from the previous write's address restarts the load at tap A.
- R6: A write to an address other than the two bank addresses (bank 0 at 5, bank 1 at 6) changes neither the weights nor the active bank.
- R7: One write happens per interval in which cs_n and ld_n are both low, and it is taken when that interval ends. If only one strobe is low, or both are held low, the outputs do not change.
- R8: Switching to a bank does not alter the weights stored in the other bank.
- R9: A write becomes visible on the third rising clock edge after the strobe interval ends. It is not visible after the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_addr | input | 3 | Write address (5 selects bank 0, 6 selects bank 1) |
| wr_data | input | 8 | Weight to write |
| cs_n | input | 1 | Active-low chip-select strobe |
| ld_n | input | 1 | Active-low load strobe |
| coef_out | output | 72 | Nine weights of the active bank, tap k on bits 8k+7:8k |

## Verification
On every cycle, the assertions check the following. The detected write is always a single-cycle pulse. The tap index never passes nine. A bank with no write enable keeps its weights. The active-bank register moves only on a write to a bank address, and an address change restarts the index at tap A. Some properties need a known sequence of host writes, and only the bench scenarios can show them. These are the A-to-I load order, the overflow writes being ignored, the untouched shadow bank reappearing after a swap, and the exact three-edge write latency.

// File: rtl/coef_pkg.sv
package coef_pkg;
  localparam int COEF_W  = 8;
  localparam int TAP_N   = 9;
  localparam int ADDR_W  = 3;
  localparam int BANK_N  = 2;
  localparam logic [ADDR_W-1:0] BANK_BASE = 3'd5;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/coef_strobe_sync.sv
module coef_strobe_sync #(
  parameter int STAGES = coef_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic ld_n,
  output logic wr_pulse
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              held_q, held_d;
  logic              both_low;

  assign both_low = ~cs_n & ~ld_n;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], both_low};
    held_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      held_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      held_q <= held_d;
    end
  end

  // falling edge of the synchronized "both low" condition
  assign wr_pulse = held_q & ~sync_q[STAGES-1];

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);
endmodule

// File: rtl/coef_load_seq.sv
module coef_load_seq #(
  parameter int ADDR_W = coef_pkg::ADDR_W,
  parameter int TAP_N  = coef_pkg::TAP_N,
  parameter int BANK_N = coef_pkg::BANK_N,
  parameter logic [ADDR_W-1:0] BANK_BASE = coef_pkg::BANK_BASE,
  localparam int IDX_W = $clog2(TAP_N + 1),
  localparam int SEL_W = (BANK_N > 1) ? $clog2(BANK_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pulse,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [BANK_N-1:0] bank_we,
  output logic [IDX_W-1:0]  wr_slot,
  output logic [SEL_W-1:0]  act_sel
);
  logic [ADDR_W-1:0] last_q, last_d;
  logic              seen_q, seen_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [SEL_W-1:0]  act_q, act_d;
  logic [BANK_N-1:0] hit_vec;
  logic              any_hit, same_addr, room;
  logic [SEL_W-1:0]  hit_sel;
  logic [IDX_W-1:0]  eff_idx;

  for (genvar b = 0; b < BANK_N; b++) begin : g_hit
    assign hit_vec[b] = (wr_addr == BANK_BASE + ADDR_W'(b));
  end

  always_comb begin
    hit_sel = '0;
    for (int b = 0; b < BANK_N; b++)
      if (hit_vec[b]) hit_sel = SEL_W'(b);
  end

  assign any_hit   = |hit_vec;
  assign same_addr = seen_q && (wr_addr == last_q);
  assign eff_idx   = same_addr ? idx_q : '0;
  assign room      = eff_idx < IDX_W'(TAP_N);

  always_comb begin
    last_d = last_q;
    seen_d = seen_q;
    idx_d  = idx_q;
    act_d  = act_q;
    if (wr_pulse) begin
      last_d = wr_addr;
      seen_d = 1'b1;
      if (any_hit) begin
        act_d = hit_sel;
        idx_d = room ? eff_idx + IDX_W'(1) : eff_idx;
      end else begin
        idx_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      seen_q <= 1'b0;
      idx_q  <= '0;
      act_q  <= '0;
    end else begin
      last_q <= last_d;
      seen_q <= seen_d;
      idx_q  <= idx_d;
      act_q  <= act_d;
    end
  end

  assign bank_we = (wr_pulse && room) ? hit_vec : '0;
  assign wr_slot = eff_idx;
  assign act_sel = act_q;

  assert_idx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_W'(TAP_N));
  assert_restart_at_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && any_hit && !same_addr) |=> (idx_q == IDX_W'(1)));
  assert_other_addr_keeps_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && !any_hit) |=> $stable(act_q));
  assert_sel_moves_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pulse |=> $stable(act_q));
endmodule

// File: rtl/coef_bank_store.sv
module coef_bank_store #(
  parameter int COEF_W = coef_pkg::COEF_W,
  parameter int TAP_N  = coef_pkg::TAP_N,
  parameter int BANK_N = coef_pkg::BANK_N,
  localparam int IDX_W  = $clog2(TAP_N + 1),
  localparam int BANK_W = COEF_W * TAP_N
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [BANK_N-1:0]        bank_we,
  input  logic [IDX_W-1:0]         wr_slot,
  input  logic [COEF_W-1:0]        wr_data,
  output logic [BANK_N*BANK_W-1:0] bank_flat
);
  for (genvar b = 0; b < BANK_N; b++) begin : g_bank
    for (genvar t = 0; t < TAP_N; t++) begin : g_tap
      logic [COEF_W-1:0] tap_q, tap_d;
      logic              tap_en;

      assign tap_en = bank_we[b] && (wr_slot == IDX_W'(t));

      always_comb begin
        tap_d = tap_q;
        if (tap_en) tap_d = wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap_q <= '0;
        else        tap_q <= tap_d;
      end

      assign bank_flat[b*BANK_W + t*COEF_W +: COEF_W] = tap_q;
    end

    assert_idle_bank_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_we[b] |=> $stable(bank_flat[b*BANK_W +: BANK_W]));
  end
endmodule

// File: rtl/coef_out_mux.sv
module coef_out_mux #(
  parameter int COEF_W = coef_pkg::COEF_W,
  parameter int TAP_N  = coef_pkg::TAP_N,
  parameter int BANK_N = coef_pkg::BANK_N,
  localparam int BANK_W = COEF_W * TAP_N,
  localparam int SEL_W  = (BANK_N > 1) ? $clog2(BANK_N) : 1
) (
  input  logic [BANK_N*BANK_W-1:0] bank_flat,
  input  logic [SEL_W-1:0]         act_sel,
  output logic [BANK_W-1:0]        coef_out
);
  always_comb begin
    coef_out = bank_flat[BANK_W-1:0];
    for (int b = 0; b < BANK_N; b++)
      if (act_sel == SEL_W'(b)) coef_out = bank_flat[b*BANK_W +: BANK_W];
  end
endmodule

// File: rtl/coef_bank_file.sv
module coef_bank_file #(
  parameter int COEF_W = coef_pkg::COEF_W,
  parameter int TAP_N  = coef_pkg::TAP_N,
  parameter int ADDR_W = coef_pkg::ADDR_W,
  parameter int BANK_N = coef_pkg::BANK_N,
  parameter logic [ADDR_W-1:0] BANK_BASE = coef_pkg::BANK_BASE,
  localparam int IDX_W  = $clog2(TAP_N + 1),
  localparam int SEL_W  = (BANK_N > 1) ? $clog2(BANK_N) : 1,
  localparam int BANK_W = COEF_W * TAP_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [COEF_W-1:0] wr_data,
  input  logic              cs_n,
  input  logic              ld_n,
  output logic [BANK_W-1:0] coef_out
);
  logic [1:0]               rst_sync_q;
  logic                     rst_int_n;
  logic                     wr_pulse;
  logic [BANK_N-1:0]        bank_we;
  logic [IDX_W-1:0]         wr_slot;
  logic [SEL_W-1:0]         act_sel;
  logic [BANK_N*BANK_W-1:0] bank_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  coef_strobe_sync u_sync (
    .clk(clk), .rst_n(rst_int_n), .cs_n(cs_n), .ld_n(ld_n), .wr_pulse(wr_pulse)
  );

  coef_load_seq #(.ADDR_W(ADDR_W), .TAP_N(TAP_N), .BANK_N(BANK_N), .BANK_BASE(BANK_BASE)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .wr_pulse(wr_pulse), .wr_addr(wr_addr),
    .bank_we(bank_we), .wr_slot(wr_slot), .act_sel(act_sel)
  );

  coef_bank_store #(.COEF_W(COEF_W), .TAP_N(TAP_N), .BANK_N(BANK_N)) u_store (
    .clk(clk), .rst_n(rst_int_n), .bank_we(bank_we), .wr_slot(wr_slot),
    .wr_data(wr_data), .bank_flat(bank_flat)
  );

  coef_out_mux #(.COEF_W(COEF_W), .TAP_N(TAP_N), .BANK_N(BANK_N)) u_mux (
    .bank_flat(bank_flat), .act_sel(act_sel), .coef_out(coef_out)
  );

  assert_one_bank_written_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(bank_we));
endmodule

// File: tb/coef_bank_file_tb.sv
module coef_bank_file_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        cs_n = 1'b1;
  logic        ld_n = 1'b1;
  logic [71:0] coef_out;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  coef_bank_file u_dut (
    .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .cs_n(cs_n), .ld_n(ld_n), .coef_out(coef_out)
  );

  // {addr, data, tap to check, expected byte}
  localparam logic [22:0] VEC [18] = '{
    {3'd5, 8'h11, 4'd0, 8'h11}, {3'd5, 8'h22, 4'd1, 8'h22}, {3'd5, 8'h33, 4'd2, 8'h33},
    {3'd5, 8'h44, 4'd3, 8'h44}, {3'd5, 8'h55, 4'd4, 8'h55}, {3'd5, 8'h66, 4'd5, 8'h66},
    {3'd5, 8'h77, 4'd6, 8'h77}, {3'd5, 8'h88, 4'd7, 8'h88}, {3'd5, 8'h99, 4'd8, 8'h99},
    {3'd5, 8'hEE, 4'd8, 8'h99}, {3'd5, 8'hEF, 4'd0, 8'h11},
    {3'd6, 8'hC1, 4'd0, 8'hC1}, {3'd6, 8'hC2, 4'd1, 8'hC2}, {3'd6, 8'hC3, 4'd2, 8'hC3},
    {3'd6, 8'hC4, 4'd3, 8'hC4},
    {3'd3, 8'h7A, 4'd0, 8'hC1},
    {3'd6, 8'hD1, 4'd0, 8'hD1},
    {3'd5, 8'h5A, 4'd1, 8'h22}
  };

  function automatic string row_tag(int i);
    if (i < 9)  return "R2";
    if (i < 11) return "R4";
    if (i < 15) return "R3";
    if (i == 15) return "R6";
    if (i == 16) return "R5";
    return "R8";
  endfunction

  task automatic check_tap(string req, int tap, logic [7:0] exp);
    n_chk++;
    if (coef_out[tap*8 +: 8] !== exp) begin
      n_bad++;
      $display("FAIL %s tap %0d: actual %h expected %h", req, tap, coef_out[tap*8 +: 8], exp);
    end
  endtask

  task automatic check_all(string req, logic [71:0] exp);
    n_chk++;
    if (coef_out !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, coef_out, exp);
    end
  endtask

  task automatic do_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; cs_n = 1'b0; ld_n = 1'b0;
    repeat (3) @(negedge clk);
    cs_n = 1'b1; ld_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [71:0] snap;
    repeat (3) @(negedge clk);
    check_all("R1 during reset", 72'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 after release", 72'h0);

    for (int i = 0; i < 18; i++) begin
      do_write(VEC[i][22:20], VEC[i][19:12]);
      check_tap(row_tag(i), int'(VEC[i][11:8]), VEC[i][7:0]);
    end
    // R8: bank 0 shows old taps, then bank 1 returns intact except tap A
    check_tap("R8", 8, 8'h99);
    do_write(3'd6, 8'hF0);
    check_tap("R3", 0, 8'hF0);
    check_tap("R8", 1, 8'hC2);
    check_tap("R8", 3, 8'hC4);

    // R7: only one strobe low -> no write
    snap = coef_out;
    @(negedge clk); wr_addr = 3'd6; wr_data = 8'hAB; ld_n = 1'b0;
    repeat (6) @(negedge clk); ld_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R7 load only", snap);
    @(negedge clk); cs_n = 1'b0;
    repeat (6) @(negedge clk); cs_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R7 select only", snap);

    // R7 + R9: held low long, then three-edge latency on release
    @(negedge clk); wr_addr = 3'd6; wr_data = 8'hF1; cs_n = 1'b0; ld_n = 1'b0;
    repeat (20) @(negedge clk);
    check_all("R7 held low", snap);
    cs_n = 1'b1; ld_n = 1'b1;
    repeat (2) @(negedge clk);
    check_tap("R9 second edge", 1, 8'hC2);
    @(negedge clk);
    check_tap("R9 third edge", 1, 8'hF1);
    repeat (3) @(negedge clk);
    check_tap("R7 single write", 2, 8'hC3);

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    check_all("R1 mid-run", 72'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_write(3'd3, 8'h44);
    check_all("R1 bank0 after reset", 72'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule